// File: doc/BRIEF.md
# Pointer-Addressed Packet Data Port

This block gives a host byte-wide access to a set of packet pages held in on-chip memory. The host never addresses the memory directly. It programs a 16-bit pointer register and a packet-number register, then moves bytes through a four-byte data window. The top bit of the pointer picks the page. When that bit is set, the page is the one at the head of the receive queue, which comes in from external queue logic. When it is clear, the page is the one named in the packet-number register. The low field of the pointer is the byte address within that page.

The pointer has two modes. In fixed mode the pointer never moves, and the low two bits of the window offset are added to it as a byte offset, so four neighbouring bytes can be reached without reprogramming. In auto-increment mode every data access uses the current address and then advances the address field by one. The field wraps within the page, and the mode and page-select bits above it are left untouched.

The host interface is a plain byte strobe interface with a 3-bit register select. A read strobe returns its byte on the following cycle, marked by a valid flag. The page size is a parameter: `PAGE_AW` = 11 gives 2 KB pages, and the default is kept smaller.

Top module: `pdp_data_port`

## Requirements
- R1: After reset, `rd_valid` is 0. Reads of the packet-number register (select 0), the pointer low byte (select 1) and the pointer high byte (select 2) all return 0.
- R2: When pointer bit 15 is 1, a data access uses page `rx_head_page`. When bit 15 is 0, it uses the page given by the low bits of the packet-number register.
- R3: The byte address of a data access is pointer bits `PAGE_AW-1:0`. In auto-increment mode it does not depend on the window offset.
- R4: When pointer bit 14 is 1, each data access (select 4 to 7, read or write) increments pointer bits `PAGE_AW-1:0` by one after the access, wrapping to 0 at the end of the page. All other pointer bits are kept.
- R5: When pointer bit 14 is 0, a data access at select 4+k (k = 0..3) addresses byte (pointer field + k) modulo the page size, and the pointer does not change.
- R6: A read of the pointer high byte returns the stored byte with bit 3 (pointer bit 11) forced to 0.
- R7: Writes to select 0, 1 and 2 load one byte each: the packet number, pointer bits 7:0 and pointer bits 15:8. Each write leaves the other bytes unchanged.
- R8: A read strobe in cycle N makes `rd_valid` 1 with the requested byte on `rd_data` in cycle N+1 only.
- R9: A data write followed in the next cycle by a read of the same byte returns the newly written value.
- R10: When `bus_wr` and `bus_rd` are both 1 in the same cycle, the write is performed and the read is dropped: no `rd_valid` follows.
- R11: Select 3 reads as 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_rd | input | 1 | Read strobe, one byte per cycle |
| bus_addr | input | 3 | Register select: 0 packet number, 1 pointer low, 2 pointer high, 3 spare, 4 to 7 data window |
| bus_wdata | input | 8 | Write byte |
| rx_head_page | input | $clog2(PAGES) | Page number at the head of the receive queue |
| rd_data | output | 8 | Read byte, valid when rd_valid is 1 |
| rd_valid | output | 1 | Marks the cycle that carries read data |

## Verification
The bench fills every page in auto-increment mode. It then reads each page back starting two bytes before the end, so the address wraps mid-sweep; a design that carried out of the address field would corrupt the mode bits or the page selection. Fixed-mode sweeps start near the top of a page, where a design that forgot the modulo would read from the next page, and where a design that moved the pointer in fixed mode would return shifted data. It also checks: the masked pointer bit 11 on read-back; the page select switching between the queue head and the packet number; a write followed at once by a read of the same byte, which catches a stale read port; and a same-cycle write and read, which must produce no valid flag.

// File: rtl/pdp_pkg.sv
package pdp_pkg;
  localparam int PTR_W       = 16;
  localparam int PTR_RX_BIT  = 15;
  localparam int PTR_INC_BIT = 14;
  localparam logic [7:0] PTR_HI_RD_MASK = 8'hF7;

  typedef enum logic [1:0] {
    SEL_PNUM   = 2'd0,
    SEL_PTR_LO = 2'd1,
    SEL_PTR_HI = 2'd2,
    SEL_SPARE  = 2'd3
  } reg_sel_e;

  function automatic logic is_window(input logic [2:0] a);
    return a[2];
  endfunction
endpackage

// File: rtl/pdp_ptr_reg.sv
module pdp_ptr_reg
  import pdp_pkg::*;
#(
  parameter int PAGES   = 4,
  parameter int PAGE_AW = 9,
  localparam int PG_W   = $clog2(PAGES),
  localparam int MEM_AW = PG_W + PAGE_AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [2:0]        addr,
  input  logic [7:0]        wdata,
  input  logic [PG_W-1:0]   rx_head_page,
  output logic              acc,
  output logic              acc_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [PTR_W-1:0]  ptr_q,
  output logic [7:0]        pnum_q
);
  localparam logic [PAGE_AW-1:0] STEP = PAGE_AW'(1);

  logic              win;
  logic [PAGE_AW-1:0] off_add;
  logic [PAGE_AW-1:0] byte_addr;
  logic [PG_W-1:0]    page;

  assign win     = is_window(addr);
  assign acc     = win && (wr || rd);
  assign acc_we  = win && wr;
  assign off_add = ptr_q[PTR_INC_BIT] ? '0 : PAGE_AW'(addr[1:0]);
  assign byte_addr = ptr_q[PAGE_AW-1:0] + off_add;
  assign page    = ptr_q[PTR_RX_BIT] ? rx_head_page : pnum_q[PG_W-1:0];
  assign mem_addr = {page, byte_addr};

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q  <= '0;
      pnum_q <= '0;
    end else if (wr && !win) begin
      case (reg_sel_e'(addr[1:0]))
        SEL_PNUM:   pnum_q       <= wdata;
        SEL_PTR_LO: ptr_q[7:0]   <= wdata;
        SEL_PTR_HI: ptr_q[15:8]  <= wdata;
        default:    ;
      endcase
    end else if (acc && ptr_q[PTR_INC_BIT]) begin
      ptr_q[PAGE_AW-1:0] <= ptr_q[PAGE_AW-1:0] + STEP;
    end
  end
endmodule

// File: rtl/pdp_page_ram.sv
module pdp_page_ram #(
  parameter int AW    = 11,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/pdp_rd_path.sv
module pdp_rd_path
  import pdp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_reg,
  input  logic             rd_mem,
  input  logic [1:0]       sel,
  input  logic [PTR_W-1:0] ptr_q,
  input  logic [7:0]       pnum_q,
  input  logic [7:0]       ram_q,
  output logic [7:0]       rd_data,
  output logic             rd_valid
);
  logic [7:0] reg_byte;
  logic [7:0] reg_q;
  logic       from_mem_q;
  logic       valid_q;

  always_comb begin
    case (reg_sel_e'(sel))
      SEL_PNUM:   reg_byte = pnum_q;
      SEL_PTR_LO: reg_byte = ptr_q[7:0];
      SEL_PTR_HI: reg_byte = ptr_q[15:8] & PTR_HI_RD_MASK;
      default:    reg_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q      <= '0;
      from_mem_q <= 1'b0;
      valid_q    <= 1'b0;
    end else begin
      valid_q    <= rd_reg || rd_mem;
      from_mem_q <= rd_mem;
      if (rd_reg) reg_q <= reg_byte;
    end
  end

  assign rd_data  = from_mem_q ? ram_q : reg_q;
  assign rd_valid = valid_q;
endmodule

// File: rtl/pdp_data_port.sv
module pdp_data_port
  import pdp_pkg::*;
#(
  parameter int PAGES   = 4,
  parameter int PAGE_AW = 9
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [2:0]               bus_addr,
  input  logic [7:0]               bus_wdata,
  input  logic [$clog2(PAGES)-1:0] rx_head_page,
  output logic [7:0]               rd_data,
  output logic                     rd_valid
);
  localparam int PG_W   = $clog2(PAGES);
  localparam int MEM_AW = PG_W + PAGE_AW;

  logic              acc;
  logic              acc_we;
  logic [MEM_AW-1:0] mem_addr;
  logic [PTR_W-1:0]  ptr_q;
  logic [7:0]        pnum_q;
  logic [7:0]        ram_q;
  logic              rd_only;
  logic              rd_mem;
  logic              rd_reg;

  assign rd_only = bus_rd && !bus_wr;
  assign rd_mem  = rd_only && is_window(bus_addr);
  assign rd_reg  = rd_only && !is_window(bus_addr);

  pdp_ptr_reg #(.PAGES(PAGES), .PAGE_AW(PAGE_AW)) u_ptr (
    .clk(clk), .rst(rst), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .rx_head_page(rx_head_page), .acc(acc),
    .acc_we(acc_we), .mem_addr(mem_addr), .ptr_q(ptr_q), .pnum_q(pnum_q)
  );

  pdp_page_ram #(.AW(MEM_AW)) u_ram (
    .clk(clk), .we(acc_we), .re(rd_mem), .addr(mem_addr),
    .wdata(bus_wdata), .rdata(ram_q)
  );

  pdp_rd_path u_rd (
    .clk(clk), .rst(rst), .rd_reg(rd_reg), .rd_mem(rd_mem),
    .sel(bus_addr[1:0]), .ptr_q(ptr_q), .pnum_q(pnum_q), .ram_q(ram_q),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );
endmodule

// File: rtl/pdp_data_port_chk.sv
module pdp_data_port_chk #(
  parameter int PAGE_AW = 9
) (
  input logic        clk,
  input logic        rst,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [2:0]  bus_addr,
  input logic [7:0]  bus_wdata,
  input logic [7:0]  rd_data,
  input logic        rd_valid,
  input logic [15:0] ptr_q,
  input logic [7:0]  pnum_q
);
  localparam logic [PAGE_AW-1:0] STEP = PAGE_AW'(1);

  // R8
  rd_valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr) |=> rd_valid);

  // R10
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_rd || bus_wr) |=> !rd_valid);

  // R4
  auto_inc_step_chk: assert property (@(posedge clk) disable iff (rst)
    ((bus_rd || bus_wr) && bus_addr[2] && ptr_q[14])
    |=> ptr_q[PAGE_AW-1:0] == $past(ptr_q[PAGE_AW-1:0]) + STEP);

  // R4
  auto_inc_upper_kept_chk: assert property (@(posedge clk) disable iff (rst)
    ((bus_rd || bus_wr) && bus_addr[2] && ptr_q[14])
    |=> ptr_q[15:PAGE_AW] == $past(ptr_q[15:PAGE_AW]));

  // R5
  fixed_ptr_still_chk: assert property (@(posedge clk) disable iff (rst)
    ((bus_rd || bus_wr) && bus_addr[2] && !ptr_q[14]) |=> $stable(ptr_q));

  // R6
  ptr_hi_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr && bus_addr == 3'd2) |=> !rd_data[3]);

  // R7
  pnum_load_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 3'd0) |=> pnum_q == $past(bus_wdata));
endmodule

bind pdp_data_port pdp_data_port_chk #(.PAGE_AW(PAGE_AW)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_data(rd_data),
  .rd_valid(rd_valid), .ptr_q(ptr_q), .pnum_q(pnum_q)
);

// File: tb/pdp_data_port_bench.sv
module pdp_data_port_bench;
  localparam int PG = 4;
  localparam int AW = 6;
  localparam int N  = 1 << AW;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [1:0] rx_head_page = '0;
  logic [7:0] rd_data;
  logic       rd_valid;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [7:0] model [PG][N];
  logic [7:0] got;
  logic       gv;

  always #2 clk = ~clk;

  pdp_data_port #(.PAGES(PG), .PAGE_AW(AW)) u_pdp_data_port (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rx_head_page(rx_head_page),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  function automatic logic [7:0] pat(input int pg, input int i);
    return 8'((pg * 37 + i * 11 + 3) & 255);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [2:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [2:0] a);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    got = rd_data; gv = rd_valid;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input int exp);
    do_rd(a);
    check({req, " valid"}, int'(gv), 1);
    check(req, int'(got), exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 valid idle", int'(rd_valid), 0);
    rd_chk("R1 pnum", 3'd0, 0);
    rd_chk("R1 ptr lo", 3'd1, 0);
    rd_chk("R1 ptr hi", 3'd2, 0);

    // R4 fill each page in auto mode, checking wrap back to 0
    for (int pg = 0; pg < PG; pg++) begin
      do_wr(3'd0, 8'(pg));
      do_wr(3'd1, 8'h00);
      do_wr(3'd2, 8'h40);
      for (int i = 0; i < N; i++) begin
        model[pg][i] = pat(pg, i);
        do_wr(3'(4 + (i % 4)), pat(pg, i));
      end
      rd_chk("R4 wrapped lo", 3'd1, 0);
      rd_chk("R4 upper kept", 3'd2, 8'h40);
    end

    // R3 R4 auto read sweep across the wrap, offset ignored
    for (int pg = 0; pg < PG; pg++) begin
      do_wr(3'd0, 8'(pg));
      do_wr(3'd1, 8'h3E);
      do_wr(3'd2, 8'h40);
      for (int i = 0; i < N; i++)
        rd_chk("R3 auto read", 3'(4 + (i % 4)), int'(model[pg][(62 + i) % N]));
      rd_chk("R4 full lap", 3'd1, 8'h3E);
    end

    // R5 fixed mode with window offsets, wrap in page
    for (int pg = 0; pg < PG; pg++) begin
      do_wr(3'd0, 8'(pg));
      do_wr(3'd2, 8'h00);
      for (int b = 0; b < 4; b++) begin
        int base;
        base = (b == 0) ? 0 : (b == 1) ? 17 : (b == 2) ? 61 : 63;
        do_wr(3'd1, 8'(base));
        for (int k = 0; k < 4; k++)
          rd_chk("R5 fixed read", 3'(4 + k), int'(model[pg][(base + k) % N]));
        rd_chk("R5 ptr unchanged", 3'd1, base);
      end
    end

    // R2 page select from receive queue head
    do_wr(3'd0, 8'h00);
    do_wr(3'd1, 8'd5);
    do_wr(3'd2, 8'h80);
    for (int r = 0; r < PG; r++) begin
      rx_head_page = 2'(r);
      rd_chk("R2 rx head page", 3'd5, int'(model[r][6]));
    end
    do_wr(3'd2, 8'h00);
    rx_head_page = 2'd3;
    rd_chk("R2 pnum page", 3'd5, int'(model[0][6]));

    // R6 R7 byte writes and masked high read
    do_wr(3'd2, 8'hFF);
    rd_chk("R6 hi masked", 3'd2, 8'hF7);
    do_wr(3'd1, 8'hA5);
    rd_chk("R7 lo", 3'd1, 8'hA5);
    rd_chk("R7 hi kept", 3'd2, 8'hF7);
    do_wr(3'd0, 8'h5C);
    rd_chk("R7 pnum", 3'd0, 8'h5C);
    rd_chk("R7 lo kept", 3'd1, 8'hA5);

    // R11 spare select
    do_wr(3'd3, 8'hFF);
    rd_chk("R11 spare reads 0", 3'd3, 0);
    rd_chk("R11 pnum kept", 3'd0, 8'h5C);
    rd_chk("R11 ptr kept", 3'd2, 8'hF7);

    // R9 write then read same byte next cycle
    do_wr(3'd0, 8'd2);
    do_wr(3'd2, 8'h00);
    do_wr(3'd1, 8'd10);
    do_wr(3'd5, 8'hC3);
    rd_chk("R9 back to back", 3'd5, 8'hC3);

    // R8 valid lasts one cycle
    @(negedge clk);
    check("R8 valid one cycle", int'(rd_valid), 0);

    // R10 simultaneous write and read
    bus_wr = 1'b1; bus_rd = 1'b1; bus_addr = 3'd6; bus_wdata = 8'h3C;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    check("R10 no valid", int'(rd_valid), 0);
    rd_chk("R10 write done", 3'd6, 8'h3C);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule